// File: doc/BRIEF.md
# Word-Addressed Register Slave with Optional Wait State

This block is a bus slave in WISHBONE style that fronts a small bank of word-wide registers. Each register is selected by a word address. Per-byte select bits decide which byte lanes of a write land in storage. A master opens a transfer by raising cycle and strobe together. The slave closes it with a single-cycle acknowledge, or with a single-cycle error strobe when the transfer is abandoned. The handshake works like valid/ready. Strobe is the valid: the master holds it, together with address and write controls, until it sees the acknowledge. Acknowledge is the ready. A fresh transfer may begin on the very next cycle.

A parameter selects the timing. With no wait state, the slave decodes the live address and acknowledges in the same cycle the strobe appears. With one wait state, the slave only captures the address on the first strobed cycle. On the second cycle it decodes that captured address, drives read data or commits write data, and acknowledges. In this mode the address only has to be valid in the first cycle, while write data and byte selects are taken in the second. If strobe has gone low by the second cycle, the slave gives no acknowledge and raises the error strobe instead.

Top module: `wbs_regfile`

## Requirements
- R1: After reset, every register reads 0 and both acknowledge and error are low.
- R2: With no wait state, a cycle with cycle and strobe both high is acknowledged in that same cycle, and read data for the live address is valid then.
- R3: With one wait state, the first strobed cycle of a transfer is never acknowledged. The second cycle is acknowledged if strobe is still high.
- R4: With one wait state, the register used is the one addressed in the first cycle. A different address shown in the second cycle has no effect.
- R5: With one wait state, write data and byte selects are taken in the acknowledge cycle. Values shown in the first cycle are not used.
- R6: With one wait state, a transfer whose strobe drops before the second cycle raises the error output for exactly one cycle, gets no acknowledge and writes nothing. With no wait state the error output stays low.
- R7: Byte select bit i gates write data bits [8i+7:8i]. Lanes whose select bit is 0 keep their old value.
- R8: Word addresses at or above the register count are unmapped. Reads there are acknowledged and return 0, and writes there change no register.
- R9: Acknowledge and error are never high together. With one wait state, acknowledge never stays high for two cycles in a row, and a strobe held straight through starts a new transfer on the cycle after the acknowledge.
- R10: Read data is 0 in every cycle without an acknowledge of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Transfer strobe (valid) |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | ADR_W | Word address |
| wb_dat_i | input | DATA_W | Write data |
| wb_sel_i | input | DATA_W/8 | Byte-lane write enables |
| wb_dat_o | output | DATA_W | Read data, valid with acknowledge |
| wb_ack_o | output | 1 | Transfer acknowledge (ready) |
| wb_err_o | output | 1 | Abandoned-transfer error strobe |

## Verification
On every cycle the assertions check the handshake shape: acknowledge only under a live strobe, acknowledge and error never together, single-cycle acknowledge and error pulses in wait-state mode, same-cycle acknowledge in zero-wait mode, and read data held at zero outside a read acknowledge. Only the bench scenarios can show what ends up in storage. This covers which address and which write data were sampled in which cycle, byte-lane merging, that unmapped and abandoned writes leave storage untouched, and the values read back. The bench compares these against a model of its own for both timing modes.

// File: rtl/wbs_regfile_pkg.sv
package wbs_regfile_pkg;
  // Phase of a transfer in wait-state mode
  typedef enum logic [0:0] {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } wbs_phase_e;
endpackage

// File: rtl/wbs_addr_stage.sv
module wbs_addr_stage
  import wbs_regfile_pkg::*;
#(
  parameter int ADR_W      = 4,
  parameter bit WAIT_STATE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [ADR_W-1:0] adr_i,
  output logic [ADR_W-1:0] eff_adr_o,
  output logic             ack_o,
  output logic             err_o
);
  if (WAIT_STATE) begin : g_wait
    wbs_phase_e       phase_q;
    logic [ADR_W-1:0] adr_q;

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        phase_q <= PH_ADDR;
        adr_q   <= '0;
      end else begin
        unique case (phase_q)
          PH_ADDR: if (req_i) begin
            phase_q <= PH_DATA;
            adr_q   <= adr_i;
          end
          PH_DATA: phase_q <= PH_ADDR;
          default: phase_q <= PH_ADDR;
        endcase
      end
    end

    assign eff_adr_o = adr_q;
    assign ack_o     = (phase_q == PH_DATA) && req_i;
    assign err_o     = (phase_q == PH_DATA) && !req_i;
  end else begin : g_direct
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign eff_adr_o  = adr_i;
    assign ack_o      = req_i;
    assign err_o      = 1'b0;
  end
endmodule

// File: rtl/wbs_decode.sv
module wbs_decode #(
  parameter int ADR_W = 4,
  parameter int DEPTH = 8
) (
  input  logic [ADR_W-1:0]         adr_i,
  output logic                     hit_o,
  output logic [$clog2(DEPTH)-1:0] idx_o
);
  localparam int IDX_W = $clog2(DEPTH);

  assign hit_o = ({1'b0, adr_i} < (ADR_W+1)'(DEPTH));
  assign idx_o = adr_i[IDX_W-1:0];
endmodule

// File: rtl/wbs_reg_bank.sv
module wbs_reg_bank #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [$clog2(DEPTH)-1:0] idx_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [DATA_W/8-1:0]      wr_sel_i,
  output logic [DATA_W-1:0]        rd_data_o
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              hit_w;
    assign hit_w = wr_en_i && (idx_i == w[$clog2(DEPTH)-1:0]);

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        word_q <= '0;
      end else if (hit_w) begin
        for (int l = 0; l < LANES; l++) begin
          if (wr_sel_i[l]) word_q[l*8 +: 8] <= wr_data_i[l*8 +: 8];
        end
      end
    end

    assign words[w] = word_q;
  end

  assign rd_data_o = words[idx_i];
endmodule

// File: rtl/wbs_regfile.sv
module wbs_regfile #(
  parameter int DATA_W     = 16,
  parameter int ADR_W      = 4,
  parameter int DEPTH      = 8,
  parameter bit WAIT_STATE = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wb_cyc_i,
  input  logic                wb_stb_i,
  input  logic                wb_we_i,
  input  logic [ADR_W-1:0]    wb_adr_i,
  input  logic [DATA_W-1:0]   wb_dat_i,
  input  logic [DATA_W/8-1:0] wb_sel_i,
  output logic [DATA_W-1:0]   wb_dat_o,
  output logic                wb_ack_o,
  output logic                wb_err_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             req;
  logic [ADR_W-1:0] eff_adr;
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] rd_word;

  assign req = wb_cyc_i && wb_stb_i;

  wbs_addr_stage #(.ADR_W(ADR_W), .WAIT_STATE(WAIT_STATE)) u_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .adr_i    (wb_adr_i),
    .eff_adr_o(eff_adr),
    .ack_o    (wb_ack_o),
    .err_o    (wb_err_o)
  );

  wbs_decode #(.ADR_W(ADR_W), .DEPTH(DEPTH)) u_dec (
    .adr_i(eff_adr),
    .hit_o(hit),
    .idx_o(idx)
  );

  wbs_reg_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wb_ack_o && wb_we_i && hit),
    .idx_i    (idx),
    .wr_data_i(wb_dat_i),
    .wr_sel_i (wb_sel_i),
    .rd_data_o(rd_word)
  );

  assign wb_dat_o = (wb_ack_o && !wb_we_i && hit) ? rd_word : '0;
endmodule

// File: rtl/wbs_regfile_chk.sv
module wbs_regfile_chk #(
  parameter int DATA_W     = 16,
  parameter bit WAIT_STATE = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cyc,
  input logic              stb,
  input logic              we,
  input logic              ack,
  input logic              err,
  input logic [DATA_W-1:0] dat_r
);
  logic req;
  assign req = cyc && stb;

  assert_ack_err_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack && err));

  assert_ack_needs_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |-> req);

  assert_rdata_idle_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack && !we) |-> (dat_r == '0));

  if (WAIT_STATE) begin : g_wait
    assert_ack_second_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack |-> ($past(req) && !$past(ack)));

    assert_ack_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack |=> !ack);

    assert_err_after_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err |-> ($past(req) && !req));

    assert_err_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err |=> !err);
  end else begin : g_direct
    assert_zero_wait_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req |-> ack);

    assert_no_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !err);
  end
endmodule

bind wbs_regfile wbs_regfile_chk #(.DATA_W(DATA_W), .WAIT_STATE(WAIT_STATE)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cyc   (wb_cyc_i),
  .stb   (wb_stb_i),
  .we    (wb_we_i),
  .ack   (wb_ack_o),
  .err   (wb_err_o),
  .dat_r (wb_dat_o)
);

// File: tb/sim_wbs_regfile.sv
module sim_wbs_regfile;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          cyc_w = 0, stb_w = 0, cyc_z = 0, stb_z = 0;
  logic          we = 0;
  logic [AW-1:0] adr = '0;
  logic [DW-1:0] dat = '0;
  logic [1:0]    sel = '0;
  logic [DW-1:0] dr_w, dr_z;
  logic          ack_w, err_w, ack_z, err_z;

  logic [DW-1:0] mdl_w [16];
  logic [DW-1:0] mdl_z [16];

  int n_run = 0;
  int n_fail = 0;

  wbs_regfile #(.DATA_W(DW), .ADR_W(AW), .DEPTH(DEPTH), .WAIT_STATE(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wb_cyc_i(cyc_w), .wb_stb_i(stb_w), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(dat), .wb_sel_i(sel), .wb_dat_o(dr_w),
    .wb_ack_o(ack_w), .wb_err_o(err_w));

  wbs_regfile #(.DATA_W(DW), .ADR_W(AW), .DEPTH(DEPTH), .WAIT_STATE(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .wb_cyc_i(cyc_z), .wb_stb_i(stb_z), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(dat), .wb_sel_i(sel), .wb_dat_o(dr_z),
    .wb_ack_o(ack_z), .wb_err_o(err_z));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R7: lane i of the old word replaced when sel[i] is set
  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] d, logic [1:0] s);
    logic [DW-1:0] r = old;
    for (int l = 0; l < 2; l++) if (s[l]) r[l*8 +: 8] = d[l*8 +: 8];
    return r;
  endfunction

  // R8: unmapped words read as zero
  function automatic logic [DW-1:0] exp_w(logic [AW-1:0] a);
    return (a < DEPTH) ? mdl_w[a] : '0;
  endfunction
  function automatic logic [DW-1:0] exp_z(logic [AW-1:0] a);
    return (a < DEPTH) ? mdl_z[a] : '0;
  endfunction

  // Wait-state transfer; optional address swap in cycle 2 (R4), junk data in cycle 1 (R5)
  task automatic xfer_w(bit w, logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] s,
                        bit swap, logic [AW-1:0] a_alt);
    @(negedge clk);
    cyc_w = 1; stb_w = 1; we = w; adr = a; dat = ~d; sel = ~s;
    #1 check("R3 first cycle ack", ack_w, 0);
    check("R10 idle rdata", dr_w, 0);
    @(negedge clk);
    if (swap) adr = a_alt;
    dat = d; sel = s;
    #1 check("R3 second cycle ack", ack_w, 1);
    check("R9 no err with ack", err_w, 0);
    if (!w) check("R4/R8 read data", dr_w, exp_w(a));
    @(negedge clk);
    cyc_w = 0; stb_w = 0;
    if (w && a < DEPTH) mdl_w[a] = merge(mdl_w[a], d, s);
    #1 check("R9 ack dropped", ack_w, 0);
  endtask

  task automatic xfer_z(bit w, logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] s);
    @(negedge clk);
    cyc_z = 1; stb_z = 1; we = w; adr = a; dat = d; sel = s;
    #1 check("R2 same cycle ack", ack_z, 1);
    check("R6 zero-wait err low", err_z, 0);
    if (!w) check("R2/R8 read data", dr_z, exp_z(a));
    @(negedge clk);
    cyc_z = 0; stb_z = 0;
    if (w && a < DEPTH) mdl_z[a] = merge(mdl_z[a], d, s);
    #1 check("R2 ack follows strobe", ack_z, 0);
  endtask

  task automatic abort_w(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    cyc_w = 1; stb_w = 1; we = 1; adr = a; dat = d; sel = 2'b11;
    #1 check("R6 no err first cycle", err_w, 0);
    @(negedge clk);
    cyc_w = 0; stb_w = 0;
    #1 check("R6 err raised", err_w, 1);
    check("R6 no ack on abort", ack_w, 0);
    @(negedge clk);
    #1 check("R6 err one cycle", err_w, 0);
    xfer_w(0, a, '0, 2'b00, 0, '0); // R6 storage unchanged
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1d5e_ed07);
    for (int i = 0; i < 16; i++) begin mdl_w[i] = '0; mdl_z[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 check("R1 ack_w reset", ack_w, 0);
    check("R1 err_w reset", err_w, 0);
    check("R1 ack_z reset", ack_z, 0);
    for (int a = 0; a < 16; a++) xfer_z(0, AW'(a), '0, 2'b00); // R1 all zero
    xfer_w(0, 4'd3, '0, 2'b00, 0, '0);

    // R7 byte lanes, both modes
    xfer_w(1, 4'd2, 16'hA1B2, 2'b11, 0, '0);
    xfer_w(1, 4'd2, 16'hFFEE, 2'b01, 0, '0);
    xfer_w(0, 4'd2, '0, 2'b00, 0, '0);
    check("R7 low lane only", mdl_w[2], 16'hA1EE);
    xfer_w(1, 4'd2, 16'h5566, 2'b10, 0, '0);
    xfer_w(0, 4'd2, '0, 2'b00, 0, '0);
    xfer_z(1, 4'd5, 16'h1234, 2'b11);
    xfer_z(1, 4'd5, 16'hABCD, 2'b10);
    xfer_z(0, 4'd5, '0, 2'b00);
    check("R7 high lane only", mdl_z[5], 16'hAB34);

    // R4 address swap in cycle 2
    xfer_w(1, 4'd1, 16'hC0DE, 2'b11, 1, 4'd6);
    xfer_w(0, 4'd6, '0, 2'b00, 0, '0);
    xfer_w(0, 4'd1, '0, 2'b00, 1, 4'd2);

    // R8 unmapped
    xfer_w(1, 4'd9, 16'hDEAD, 2'b11, 0, '0);
    xfer_w(0, 4'd9, '0, 2'b00, 0, '0);
    xfer_w(0, 4'd1, '0, 2'b00, 0, '0);
    xfer_z(1, 4'd12, 16'hBEEF, 2'b11);
    xfer_z(0, 4'd12, '0, 2'b00);
    xfer_z(0, 4'd4, '0, 2'b00);

    // R6 abort
    abort_w(4'd7, 16'h7777);
    abort_w(4'd1, 16'h0000);

    // R9 back-to-back with strobe held
    @(negedge clk);
    cyc_w = 1; stb_w = 1; we = 0; adr = 4'd1;
    @(negedge clk);
    #1 check("R9 b2b first ack", ack_w, 1);
    check("R9 b2b first data", dr_w, exp_w(4'd1));
    @(negedge clk);
    adr = 4'd2;
    #1 check("R9 new transfer no ack", ack_w, 0);
    @(negedge clk);
    #1 check("R9 b2b second ack", ack_w, 1);
    check("R9 b2b second data", dr_w, exp_w(4'd2));
    @(negedge clk);
    cyc_w = 0; stb_w = 0;

    // Random traffic
    for (int i = 0; i < 400; i++) begin
      bit            mode = 1'($urandom);
      bit            w    = 1'($urandom);
      logic [AW-1:0] a    = AW'($urandom);
      logic [DW-1:0] d    = DW'($urandom);
      logic [1:0]    s    = 2'($urandom);
      if ($urandom % 10 == 0) abort_w(a, d);
      else if (mode) xfer_w(w, a, d, s, 1'($urandom), AW'($urandom));
      else xfer_z(w, a, d, s);
    end
    for (int a = 0; a < 16; a++) begin
      xfer_w(0, AW'(a), '0, 2'b00, 0, '0);
      xfer_z(0, AW'(a), '0, 2'b00);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule